// File: doc/BRIEF.md
# Floating-Point Issue Scoreboard Interlock

This block sits in the issue stage of a single-precision floating-point coprocessor. Each cycle it sees at most one candidate instruction and decides whether that instruction may issue. The instruction carries a class (multiply/add, or divide/square-root), a destination register, two source registers and a short-vector length of one to four elements. The block keeps a remaining-cycles countdown for each of the 32 scalar registers. A count of zero means the register holds a valid result. The block models timing only; it carries no operand data.

The multiply/add pipe is fully pipelined and has an 8-cycle result latency. The divide/square-root unit is not pipelined, takes 19 cycles and runs alongside the multiply pipe. In short-vector mode the register indices of each element advance by one and wrap inside their bank of eight registers. Element k finishes k cycles after element 0. A vector occupies the multiply pipe for one cycle per element. Only one result is written back per cycle. When both units would finish in the same cycle, the divide result gives way by one cycle.

Top module: `fpsb_issue_interlock`

## Requirements
- R1: After reset all registers are ready, `wb_valid` is 0, and with `in_valid` low both `issue` and `stall` are 0.
- R2: Independent scalar multiply/add instructions (class 0) issue on consecutive cycles without stalling, and `stall` is high exactly when `in_valid` is high and `issue` is low.
- R3: A multiply/add issued in cycle T reports `wb_valid` with `wb_reg` equal to its destination in cycle T+8. In that cycle the register is ready, so a dependent instruction may issue in the same cycle.
- R4: An instruction whose source register is still pending stalls, and it issues in the cycle that register's writeback is reported.
- R5: A vector of length n (`in_vlen_m1` = n-1) uses for element k the index whose upper two bits equal those of the base and whose lower three bits are (base + k) mod 8. Element k writes back k cycles after element 0.
- R6: A vector instruction stalls if any one element's source register is pending, even when all its other sources are ready.
- R7: A divide/square-root (class 1) issued in cycle T writes back its element k in cycle T+19+k, unless it is delayed under R12.
- R8: While a divide/square-root is in progress, independent multiply/add instructions issue without waiting for it.
- R9: A divide/square-root stalls while any earlier divide result is pending. It may issue in the cycle the last such result is written back.
- R10: An instruction whose destination (any element) is still pending stalls until that register is written back.
- R11: A multiply/add vector of length n issued in cycle T keeps the next multiply/add from issuing before cycle T+n.
- R12: When a multiply result and a divide result would finish in the same cycle, the multiply result is written back in that cycle and the divide result one cycle later. The divide destination becomes ready in that later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally over two cycles |
| in_valid | input | 1 | A candidate instruction is present |
| in_kind | input | 1 | 0 = multiply/add, 1 = divide/square-root |
| in_dst | input | 5 | Destination register base index |
| in_src_a | input | 5 | First source register base index |
| in_src_b | input | 5 | Second source register base index |
| in_vlen_m1 | input | 2 | Vector length minus one (0 = scalar) |
| issue | output | 1 | The candidate issues in this cycle |
| stall | output | 1 | The candidate is held in this cycle |
| wb_valid | output | 1 | A result is written back in this cycle |
| wb_reg | output | 5 | Register index of that writeback |

## Verification
A multiply/add element k is due on the writeback port exactly 8+k cycles after the cycle in which `issue` was seen high. A divide element is due 19+k cycles after issue, plus one cycle when it gives way to a multiply finishing alongside. The driver records the cycle of each issue and queues every expected writeback with its due cycle, in due order. The monitor compares the register and the exact cycle of each writeback it sees. For each stall the driver counts the cycles `issue` stays low and compares the count with the distance, worked out in advance, to the writeback or unit release that must end it. Inputs change and outputs are sampled at the falling clock edge.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;
  // log2 of the register bank size inside which vector indices wrap
  localparam int BANK_BITS = 3;

  typedef enum logic {
    K_MULADD  = 1'b0,
    K_DIVSQRT = 1'b1
  } kind_e;
endpackage

// File: rtl/fpsb_mul_slot.sv
// Tracks how many more cycles the multiply pipe's issue slot is taken by a vector.
module fpsb_mul_slot #(
  parameter int VLW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vlm1,
  output logic           busy
);
  logic [VLW-1:0] occ_q, occ_d;
  logic           occ_en;

  always_comb begin
    occ_d  = occ_q;
    occ_en = 1'b0;
    if (start) begin
      occ_d  = vlm1;
      occ_en = 1'b1;
    end else if (occ_q != '0) begin
      occ_d  = occ_q - 1'b1;
      occ_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
    end else if (occ_en) begin
      occ_q <= occ_d;
    end
  end

  assign busy = (occ_q != '0);
endmodule

// File: rtl/fpsb_hazard.sv
// Combinational hazard test across all active vector elements.
module fpsb_hazard
  import fpsb_pkg::*;
#(
  parameter int NREG = 32,
  parameter int VMAX = 4,
  parameter int RW   = 5,
  parameter int VLW  = 2
) (
  input  kind_e           kind,
  input  logic [RW-1:0]   dst,
  input  logic [RW-1:0]   src_a,
  input  logic [RW-1:0]   src_b,
  input  logic [VLW-1:0]  vlm1,
  input  logic [NREG-1:0] pending,
  input  logic            mul_busy,
  input  logic            div_busy,
  output logic            hazard
);
  localparam int BB = BANK_BITS;

  logic [VMAX-1:0] elem_hit;

  for (genvar k = 0; k < VMAX; k++) begin : g_elem
    localparam logic [BB-1:0] KOFF = BB'(k);
    logic [RW-1:0] ix_d, ix_a, ix_b;
    logic          elem_on;

    assign ix_d    = {dst[RW-1:BB],   dst[BB-1:0]   + KOFF};
    assign ix_a    = {src_a[RW-1:BB], src_a[BB-1:0] + KOFF};
    assign ix_b    = {src_b[RW-1:BB], src_b[BB-1:0] + KOFF};
    assign elem_on = (int'(vlm1) >= k);
    // source not ready (RAW) or destination still owed a result (WAW)
    assign elem_hit[k] = elem_on && (pending[ix_a] || pending[ix_b] || pending[ix_d]);
  end

  always_comb begin
    hazard = |elem_hit;
    if (kind == K_DIVSQRT) begin
      hazard = hazard || div_busy;
    end else begin
      hazard = hazard || mul_busy;
    end
  end
endmodule

// File: rtl/fpsb_regtrack.sv
// Per-register countdown of remaining result cycles, plus the single writeback port.
module fpsb_regtrack #(
  parameter int NREG    = 32,
  parameter int MUL_LAT = 8,
  parameter int DIV_LAT = 19,
  parameter int RW      = 5,
  parameter int VLW     = 2,
  parameter int CW      = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic            ld_div,
  input  logic [RW-1:0]   ld_dst,
  input  logic [VLW-1:0]  ld_vlm1,
  output logic [NREG-1:0] pending,
  output logic            div_busy,
  output logic            wb_valid,
  output logic [RW-1:0]   wb_reg
);
  localparam int BB = fpsb_pkg::BANK_BITS;
  localparam logic [CW-1:0] MUL_LD = CW'(MUL_LAT - 1);
  localparam logic [CW-1:0] DIV_LD = CW'(DIV_LAT - 1);

  logic [NREG-1:0] fin_mul, fin_div, div_pend;
  logic            hold_div;
  logic [RW-1:0]   mul_idx, div_idx;
  logic            wbv_d;
  logic [RW-1:0]   wbr_d;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam logic [RW-1:0] RIDX = RW'(r);
    logic [CW-1:0] cnt_q, cnt_d;
    logic          isdiv_q, isdiv_d;
    logic [BB-1:0] off;
    logic          hit, upd;

    always_comb begin
      off     = RIDX[BB-1:0] - ld_dst[BB-1:0];
      hit     = ld_en && (RIDX[RW-1:BB] == ld_dst[RW-1:BB]) && (off <= BB'(ld_vlm1));
      cnt_d   = cnt_q;
      isdiv_d = isdiv_q;
      upd     = 1'b0;
      if (hit) begin
        cnt_d   = (ld_div ? DIV_LD : MUL_LD) + CW'(off);
        isdiv_d = ld_div;
        upd     = 1'b1;
      end else if ((cnt_q != '0) && !(isdiv_q && hold_div)) begin
        cnt_d = cnt_q - 1'b1;
        upd   = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q   <= '0;
        isdiv_q <= 1'b0;
      end else if (upd) begin
        cnt_q   <= cnt_d;
        isdiv_q <= isdiv_d;
      end
    end

    assign pending[r]  = (cnt_q != '0);
    assign fin_mul[r]  = (cnt_q == CW'(1)) && !isdiv_q;
    assign fin_div[r]  = (cnt_q == CW'(1)) && isdiv_q;
    assign div_pend[r] = isdiv_q && (cnt_q != '0);
  end

  always_comb begin
    mul_idx = '0;
    div_idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (fin_mul[i]) mul_idx = RW'(i);
      if (fin_div[i]) div_idx = RW'(i);
    end
    // multiply wins the port; every divide counter is frozen for one cycle
    hold_div = (|fin_mul) && (|fin_div);
    wbv_d    = (|fin_mul) || (|fin_div);
    wbr_d    = (|fin_mul) ? mul_idx : div_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_reg   <= '0;
    end else begin
      wb_valid <= wbv_d;
      wb_reg   <= wbr_d;
    end
  end

  assign div_busy = |div_pend;
endmodule

// File: rtl/fpsb_issue_interlock.sv
module fpsb_issue_interlock
  import fpsb_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int MUL_LAT = 8,
  parameter int DIV_LAT = 19,
  parameter int VMAX    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_kind,
  input  logic [$clog2(NREG)-1:0] in_dst,
  input  logic [$clog2(NREG)-1:0] in_src_a,
  input  logic [$clog2(NREG)-1:0] in_src_b,
  input  logic [$clog2(VMAX)-1:0] in_vlen_m1,
  output logic                    issue,
  output logic                    stall,
  output logic                    wb_valid,
  output logic [$clog2(NREG)-1:0] wb_reg
);
  localparam int RW  = $clog2(NREG);
  localparam int VLW = $clog2(VMAX);
  localparam int CW  = $clog2(DIV_LAT + VMAX + 1);

  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic [NREG-1:0] pending;
  logic            div_busy, mul_busy, hazard;
  kind_e           kind;

  // asynchronous assertion, release aligned to the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  assign kind  = kind_e'(in_kind);
  assign issue = in_valid && rst_sync_n && !hazard;
  assign stall = in_valid && !issue;

  fpsb_hazard #(
    .NREG(NREG), .VMAX(VMAX), .RW(RW), .VLW(VLW)
  ) u_hazard (
    .kind     (kind),
    .dst      (in_dst),
    .src_a    (in_src_a),
    .src_b    (in_src_b),
    .vlm1     (in_vlen_m1),
    .pending  (pending),
    .mul_busy (mul_busy),
    .div_busy (div_busy),
    .hazard   (hazard)
  );

  fpsb_mul_slot #(.VLW(VLW)) u_mul_slot (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (issue && (kind == K_MULADD)),
    .vlm1  (in_vlen_m1),
    .busy  (mul_busy)
  );

  fpsb_regtrack #(
    .NREG(NREG), .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT),
    .RW(RW), .VLW(VLW), .CW(CW)
  ) u_regtrack (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ld_en    (issue),
    .ld_div   (kind == K_DIVSQRT),
    .ld_dst   (in_dst),
    .ld_vlm1  (in_vlen_m1),
    .pending  (pending),
    .div_busy (div_busy),
    .wb_valid (wb_valid),
    .wb_reg   (wb_reg)
  );
endmodule

// File: rtl/fpsb_issue_interlock_chk.sv
module fpsb_issue_interlock_chk #(
  parameter int NREG = 32,
  parameter int RW   = 5
) (
  input logic            clk,
  input logic            rst_ok,
  input logic            in_valid,
  input logic            in_kind,
  input logic [RW-1:0]   in_dst,
  input logic [RW-1:0]   in_src_a,
  input logic            issue,
  input logic            stall,
  input logic            wb_valid,
  input logic [RW-1:0]   wb_reg,
  input logic [NREG-1:0] pending,
  input logic            div_busy
);
  a_r2_issue_needs_valid: assert property (@(posedge clk) disable iff (!rst_ok)
    issue |-> (in_valid && !stall));

  a_r3_issued_dst_pending: assert property (@(posedge clk) disable iff (!rst_ok)
    issue |=> pending[$past(in_dst)]);

  a_r3_wb_reg_ready: assert property (@(posedge clk) disable iff (!rst_ok)
    wb_valid |-> !pending[wb_reg]);

  a_r4_src_ready: assert property (@(posedge clk) disable iff (!rst_ok)
    issue |-> !pending[in_src_a]);

  a_r9_div_unit_idle: assert property (@(posedge clk) disable iff (!rst_ok)
    (issue && in_kind) |-> !div_busy);

  a_r10_dst_free: assert property (@(posedge clk) disable iff (!rst_ok)
    issue |-> !pending[in_dst]);
endmodule

bind fpsb_issue_interlock fpsb_issue_interlock_chk #(.NREG(NREG), .RW(RW)) u_chk (
  .clk      (clk),
  .rst_ok   (rst_sync_n),
  .in_valid (in_valid),
  .in_kind  (in_kind),
  .in_dst   (in_dst),
  .in_src_a (in_src_a),
  .issue    (issue),
  .stall    (stall),
  .wb_valid (wb_valid),
  .wb_reg   (wb_reg),
  .pending  (pending),
  .div_busy (div_busy)
);

// File: tb/test_fpsb_issue_interlock.sv
module test_fpsb_issue_interlock;
  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic       in_kind;
  logic [4:0] in_dst, in_src_a, in_src_b;
  logic [1:0] in_vlen_m1;
  logic       issue, stall, wb_valid;
  logic [4:0] wb_reg;

  int  cyc = 0;
  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  typedef struct {
    int    r;
    int    due;
    string req;
  } exp_t;
  exp_t q[$];

  fpsb_issue_interlock i_fpsb_issue_interlock (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_vlen_m1(in_vlen_m1), .issue(issue), .stall(stall),
    .wb_valid(wb_valid), .wb_reg(wb_reg)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input int r, input int due, input string req);
    exp_t e;
    int   i;
    e.r = r; e.due = due; e.req = req;
    i = 0;
    while (i < q.size() && q[i].due <= due) i++;
    q.insert(i, e);
  endtask

  // Drives one instruction, counts stall cycles, queues its writebacks.
  task automatic drive(input bit kind, input int dst, input int a, input int b,
                       input int vlm1, input int exp_stall, input int extra,
                       input string req);
    int n, t, lat;
    @(negedge clk);
    in_valid = 1'b1; in_kind = kind;
    in_dst = dst[4:0]; in_src_a = a[4:0]; in_src_b = b[4:0];
    in_vlen_m1 = vlm1[1:0];
    #1;
    n = 0;
    while (!issue && n < 100) begin
      check(stall == 1'b1, {req, " stall flag"}, int'(stall), 1);
      n++;
      @(negedge clk); #1;
    end
    t = cyc;
    check(n == exp_stall, {req, " stall cycles"}, n, exp_stall);
    lat = kind ? 19 : 8;
    for (int k = 0; k <= vlm1; k++) begin
      push((dst & 24) | ((dst + k) & 7), t + lat + k + extra, req);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // Monitor: each writeback must match the head of the queue, register and cycle.
  always @(negedge clk) begin
    if (wb_valid === 1'b1) begin
      if (q.size() == 0) begin
        check(1'b0, "unexpected writeback", int'(wb_reg), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(int'(wb_reg) == e.r, {e.req, " wb register"}, int'(wb_reg), e.r);
        check(cyc == e.due, {e.req, " wb cycle"}, cyc, e.due);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b0; in_kind = 1'b0; in_dst = '0; in_src_a = '0;
    in_src_b = '0; in_vlen_m1 = '0;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1: idle state after reset
    check(wb_valid == 1'b0, "R1 wb_valid", int'(wb_valid), 0);
    check(issue == 1'b0,    "R1 issue",    int'(issue), 0);
    check(stall == 1'b0,    "R1 stall",    int'(stall), 0);

    // R2, R3: back-to-back independent multiplies
    drive(0, 8, 16, 20, 0, 0, 0, "R2/R3 mul a");
    drive(0, 12, 21, 25, 0, 0, 0, "R2/R3 mul b");
    // R4: dependent on s9 written 8 cycles after its issue
    drive(0, 9, 1, 2, 0, 0, 0, "R4 producer");
    drive(0, 10, 3, 9, 0, 7, 0, "R4 consumer");
    idle(14);

    // R5, R11: length-4 vector then a scalar multiply held by the pipe slot
    drive(0, 14, 4, 28, 3, 0, 0, "R5 vector wrap");
    drive(0, 17, 18, 19, 0, 3, 0, "R11 slot");
    idle(16);

    // R6: vector whose last element reads pending s22; dst 30 wraps to 24/25
    drive(0, 22, 0, 1, 0, 0, 0, "R6 producer");
    drive(0, 30, 16, 19, 3, 7, 0, "R6 vector");
    idle(22);

    // R7, R8, R9: divide, independent multiply, second divide
    drive(1, 3, 4, 5, 0, 0, 0, "R7 div");
    drive(0, 11, 12, 13, 0, 0, 0, "R8 mul beside div");
    drive(1, 5, 6, 7, 0, 17, 0, "R9 second div");
    idle(42);

    // R12: divide and multiply finish together; divide gives way
    drive(1, 1, 4, 5, 0, 0, 1, "R12 div delayed");
    idle(10);
    drive(0, 2, 6, 7, 0, 0, 0, "R12 mul wins");
    drive(0, 0, 1, 2, 0, 8, 0, "R12 reader");
    idle(20);

    // R10: write-after-write on s7
    drive(0, 7, 0, 1, 0, 0, 0, "R10 first");
    drive(0, 7, 2, 3, 0, 7, 0, "R10 second");
    idle(30);

    check(q.size() == 0, "all writebacks seen", q.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule